// File: doc/BRIEF.md
# Buffered PWM Compare Channel

This block is a single compare channel for a PWM generator. Software writes a 16-bit compare value through a 32-bit bus word. The value first goes into a pending buffer. It is copied into the active compare register only when the external counter sits at zero, so the waveform never sees a threshold change partway through a period. Two commit policies are offered. The local policy commits at the next counter zero. The global policy waits for a chip-wide synchronous-update request and then commits at the first counter zero after it.

The active value is compared against the external counter on every clock. A one-cycle match pulse is raised when the two become equal, provided the active value does not exceed the period value. That pulse is meant for output-waveform, interrupt or converter-trigger logic outside this block. The counter itself and all consumers of the pulse live elsewhere.

Top module: `pwm_cmp_channel`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) rd_data, active_cmp, pend_flag and match_pulse are all zero.
- R2: A write (wr_en high at an edge) stores wr_data[15:0]. From the next cycle rd_data returns that value in bits 15:0, and bits 31:16 read as zero whatever was written there.
- R3: pend_flag is set by every write and cleared by a commit. It stays set when a write and a commit fall on the same edge.
- R4: With upd_global low, a commit happens at any edge where cnt_zero is high and pend_flag is set. active_cmp shows the committed value from the next cycle, and it does not change at any other edge.
- R5: With upd_global high, a counter zero commits only if a sync_req was accepted at an earlier edge while a value was pending. Counter zeros without such a request leave active_cmp unchanged.
- R6: A sync_req seen while pend_flag is clear is dropped. It does not enable a commit for a value written later.
- R7: A second write before commit replaces the pending value. Only the last written value is ever committed.
- R8: match_pulse is high for exactly one cycle, in the cycle after an edge at which cnt_val equals active_cmp and active_cmp is at most period_val, and only if that condition was false at the previous edge. A counter held on the match value gives one pulse.
- R9: When active_cmp is greater than period_val, match_pulse stays low.
- R10: A write on the same edge as a commit does not disturb the commit. The previously pending value becomes active, and the new value remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 32 | Bus write word; bits 15:0 hold the compare value |
| rd_data | output | 32 | Bus read word: pending value, upper half zero |
| upd_global | input | 1 | Commit policy: 0 = next zero, 1 = zero after sync request |
| sync_req | input | 1 | Global synchronous-update request pulse |
| cnt_val | input | 16 | External counter value |
| cnt_zero | input | 1 | Counter is at zero this cycle |
| period_val | input | 16 | Counter period (load) value |
| active_cmp | output | 16 | Compare value currently in force |
| pend_flag | output | 1 | A written value awaits commit |
| match_pulse | output | 1 | One-cycle compare match pulse |

## Verification
The counter is run as a free wrapping ramp in both commit policies. Writes are placed mid-period, back to back, and on the zero cycle itself, which separates commit-at-zero from commit-on-write and shows whether a rewrite replaces the pending value. In global mode, sync requests are sent both with and without a pending value, which shows whether a stale request is wrongly kept. The counter is also stalled on the match value, and compare values are set above the period, to check the single-pulse and suppression rules. A final stretch of random writes, requests, mode flips and counter stalls is compared every clock against a behavioural model.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int unsigned CMP_W = 16;
  localparam int unsigned BUS_W = 32;

  typedef logic [CMP_W-1:0] cmp_t;

  // Compare hit: counter equal to threshold and threshold reachable within the period.
  function automatic logic cmp_hit(input cmp_t cnt, input cmp_t thr, input cmp_t per);
    return (cnt == thr) && (thr <= per);
  endfunction

  // Commit decision at a counter zero for the selected policy.
  function automatic logic commit_due(input logic zero, input logic pending,
                                      input logic global_mode, input logic armed);
    return zero && pending && (!global_mode || armed);
  endfunction

  // Bus read word built from the pending value.
  function automatic logic [BUS_W-1:0] read_word(input cmp_t v);
    return {{(BUS_W-CMP_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/cmp_pending_buf.sv
module cmp_pending_buf
  import pwm_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             sync_req,
  input  logic             commit,
  output cmp_t             pend_val,
  output logic             pend_flag,
  output logic             arm_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_val  <= '0;
      pend_flag <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      if (wr_en) pend_val <= wr_data[CMP_W-1:0];
      if (wr_en)       pend_flag <= 1'b1;
      else if (commit) pend_flag <= 1'b0;
      if (commit)                      arm_q <= 1'b0;
      else if (sync_req && pend_flag)  arm_q <= 1'b1;
    end
  end

  p_write_sets_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend_flag);
  p_commit_clears_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_en) |=> !pend_flag);
  p_write_stores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend_val == $past(wr_data[CMP_W-1:0]));
  p_idle_request_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q && !pend_flag) |=> !arm_q);
endmodule

// File: rtl/cmp_active_stage.sv
module cmp_active_stage
  import pwm_cmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_zero,
  input  logic pend_flag,
  input  logic arm_q,
  input  logic upd_global,
  input  cmp_t pend_val,
  output logic commit,
  output cmp_t active_val
);
  assign commit = commit_due(cnt_zero, pend_flag, upd_global, arm_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      active_val <= '0;
    else if (commit) active_val <= pend_val;
  end

  p_hold_without_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_zero |=> $stable(active_val));
  p_global_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_global && !arm_q) |=> $stable(active_val));
  p_commit_takes_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> active_val == $past(pend_val));
endmodule

// File: rtl/cmp_match_det.sv
module cmp_match_det
  import pwm_cmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmp_t cnt_val,
  input  cmp_t period_val,
  input  cmp_t active_val,
  output logic hit,
  output logic match_pulse
);
  logic hit_q;

  assign hit = cmp_hit(cnt_val, active_val, period_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q       <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      hit_q       <= hit;
      match_pulse <= hit && !hit_q;
    end
  end

  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);
  p_pulse_needs_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(cnt_val) == $past(active_val));
  p_over_period_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(active_val) <= $past(period_val));
endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  input  logic             upd_global,
  input  logic             sync_req,
  input  logic [CMP_W-1:0] cnt_val,
  input  logic             cnt_zero,
  input  logic [CMP_W-1:0] period_val,
  output logic [CMP_W-1:0] active_cmp,
  output logic             pend_flag,
  output logic             match_pulse
);
  cmp_t pend_val;
  logic arm_q;
  logic commit;
  logic hit;

  cmp_pending_buf u_buf (
    .clk, .rst_n, .wr_en, .wr_data, .sync_req, .commit,
    .pend_val, .pend_flag, .arm_q
  );

  cmp_active_stage u_act (
    .clk, .rst_n, .cnt_zero, .pend_flag, .arm_q, .upd_global,
    .pend_val, .commit, .active_val(active_cmp)
  );

  cmp_match_det u_match (
    .clk, .rst_n, .cnt_val, .period_val, .active_val(active_cmp),
    .hit, .match_pulse
  );

  assign rd_data = read_word(pend_val);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (active_cmp == '0 && !pend_flag && !match_pulse && rd_data == '0));
endmodule

// File: tb/test_pwm_cmp_channel.sv
module test_pwm_cmp_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        upd_global = 1'b0;
  logic        sync_req = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        cnt_zero = 1'b0;
  logic [15:0] period_val = 16'd9;
  logic [15:0] active_cmp;
  logic        pend_flag;
  logic        match_pulse;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  // Behavioural reference state
  int m_pend, m_act;
  bit m_flag, m_arm, m_hitq, m_match;
  int bcnt = 0;
  bit stall = 0;

  always #5 clk = ~clk;

  pwm_cmp_channel i_pwm_cmp_channel (
    .clk, .rst_n, .wr_en, .wr_data, .rd_data, .upd_global, .sync_req,
    .cnt_val, .cnt_zero, .period_val, .active_cmp, .pend_flag, .match_pulse
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 rd_data", rd_data, m_pend);
    chk("R3 pend_flag", pend_flag, m_flag);
    chk("R4/R5 active_cmp", active_cmp, m_act);
    chk("R8 match_pulse", match_pulse, m_match);
  endtask

  // One clock: inputs already driven; model advances on the edge, compare at negedge.
  task automatic tick();
    bit hit, cm, w, s;
    int d, nact, npend;
    w = wr_en; s = sync_req; d = int'(wr_data[15:0]);
    @(posedge clk);
    hit = (int'(cnt_val) == m_act) && (m_act <= int'(period_val));
    cm  = cnt_zero && m_flag && (!upd_global || m_arm);
    m_match = hit && !m_hitq;
    m_hitq  = hit;
    nact  = cm ? m_pend : m_act;
    npend = w ? d : m_pend;
    if (cm) m_arm = 0; else if (s && m_flag) m_arm = 1;
    if (w) m_flag = 1; else if (cm) m_flag = 0;
    m_act = nact; m_pend = npend;
    if (m_match) pulses++;
    @(negedge clk);
    compare_all();
  endtask

  // Drive one cycle with the ramp counter, then advance the ramp.
  task automatic cyc(input bit w, input logic [31:0] d, input bit s);
    wr_en = w; wr_data = d; sync_req = s;
    cnt_val = bcnt[15:0]; cnt_zero = (bcnt == 0);
    tick();
    wr_en = 0; sync_req = 0;
    if (!stall) bcnt = (bcnt >= int'(period_val)) ? 0 : bcnt + 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0);
  endtask

  task automatic run_to_zero();
    while (bcnt != 0) cyc(0, '0, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    // R1: reset state
    wr_en = 1; wr_data = 32'hFFFF_FFFF; sync_req = 1;
    repeat (3) @(negedge clk);
    wr_en = 0; sync_req = 0;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 active_cmp", active_cmp, 0);
    chk("R1 pend_flag", pend_flag, 0);
    chk("R1 match_pulse", match_pulse, 0);
    m_pend = 0; m_act = 0; m_flag = 0; m_arm = 0; m_hitq = 0; m_match = 0;
    rst_n = 1;

    // R4 local mode; R2 upper bits are dropped
    run(3);
    cyc(1, 32'hABCD_0005, 0);
    chk("R2 upper zero", rd_data[31:16], 0);
    chk("R3 pending after write", pend_flag, 1);
    chk("R4 not yet active", active_cmp, 0);
    run_to_zero();
    cyc(0, '0, 0);
    chk("R4 active after zero", active_cmp, 5);
    p0 = pulses;
    run(10);
    chk("R8 one pulse per period", pulses - p0, 1);

    // R7: rewrite before commit
    run(2);
    cyc(1, 32'h0000_0003, 0);
    cyc(1, 32'h0000_0007, 0);
    run_to_zero(); cyc(0, '0, 0);
    chk("R7 last write wins", active_cmp, 7);

    // R5/R6: global mode
    upd_global = 1;
    run(4);
    cyc(0, '0, 1);             // R6: request with nothing pending
    cyc(1, 32'h0000_0002, 0);
    run_to_zero(); run(11);
    chk("R6 stale request dropped", active_cmp, 7);
    chk("R5 no commit without request", pend_flag, 1);
    cyc(0, '0, 1);
    run_to_zero(); cyc(0, '0, 0);
    chk("R5 commit after request", active_cmp, 2);

    // R9: value above the period
    upd_global = 0;
    run(3);
    cyc(1, 32'h0000_0014, 0);
    run_to_zero(); cyc(0, '0, 0);
    p0 = pulses;
    run(25);
    chk("R9 no pulse above period", pulses - p0, 0);

    // R10: write on the zero cycle
    cyc(1, 32'h0000_0004, 0);
    run_to_zero();
    cyc(1, 32'h0000_0006, 0);
    chk("R10 old pending committed", active_cmp, 4);
    chk("R10 new value pending", pend_flag, 1);
    run_to_zero(); cyc(0, '0, 0);
    chk("R10 later commit", active_cmp, 6);

    // R8: counter stalled on the match value
    while (bcnt != 6) cyc(0, '0, 0);
    stall = 1;
    p0 = pulses;
    run(6);
    stall = 0;
    run(2);
    chk("R8 single pulse on stall", pulses - p0, 1);

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if ((i % 400) == 0) upd_global = $urandom_range(0, 1);
      if ((i % 700) == 0) period_val = 16'($urandom_range(3, 12));
      if (bcnt > int'(period_val)) bcnt = 0;
      stall = ($urandom_range(0, 9) == 0);
      cyc($urandom_range(0, 7) == 0, {16'($urandom), 16'($urandom_range(0, 14))},
          $urandom_range(0, 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule